// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block reads an 8-bit, single-channel serial analog-to-digital converter over and over, with nothing but one free-running binary counter clocked by the system clock. Two counter outputs drive the converter directly. A middle bit becomes the converter's serial clock. The AND of the two top bits becomes the active-low chip-select. Every 256 system clocks make one conversion frame, which is sixteen serial-clock periods.

The serial data line is sampled into a shift register whenever the serial clock falls. Bits arrive most significant first. Each new bit enters at the low end, and older bits move toward the high end. At one decoded counter value the shift register is copied into a holding register. That register drives the 8-bit `sample` output. The output changes once per frame and is steady in between, so a display or other consumer can read it at any time. All strobes are single-cycle enables in the system clock domain. No derived clock exists.

With a 4 MHz system clock and the default parameters, the serial clock runs at 250 kHz. This is below the usual 400 kHz ceiling of such converters.

Top module: `adc_frame_reader`

## Requirements
- R1: The frame counter increments on every system clock after reset and wraps from 255 to 0. The output pattern therefore repeats exactly every 256 clocks.
- R2: `adc_sclk` equals counter bit 3. Starting at a frame boundary, it is low for 8 clocks and then high for 8 clocks, with a period of 16 clocks.
- R3: `adc_cs_n` is the AND of counter bits 7 and 6. It is low for the first 192 clocks of a frame and high for the last 64 clocks. Its falling edge coincides with the frame boundary, and `adc_sclk` is low at that point.
- R4: The shift register takes in `adc_sdata` only at a clock where `adc_sclk` falls, that is, when the counter rolls over from a value whose low four bits are all ones. The new bit enters the least significant position.
- R5: The holding register loads on the `adc_sclk` falling edge where the counter passes from 0xAF to 0xB0. `sample` therefore takes its new value 176 clocks after `adc_cs_n` falls, and the shift taken on that same edge is not part of the loaded value.
- R6: Apart from the R5 capture and reset, `sample` does not change, so it stays constant for a full frame.
- R7: A synchronous active-high reset clears the counter, the shift register and the holding register. During reset `sample` is 0, `adc_sclk` is 0 and `adc_cs_n` is 0 (selected), and a new frame begins when reset is released.
- R8: Count the `adc_sclk` falling edges while `adc_cs_n` is low, with the edge at the frame boundary not counted. The value of `adc_sdata` just before edges 3 to 10 forms `sample`, most significant bit first: the bit before edge 3 lands in `sample[7]` and the bit before edge 10 in `sample[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Serial clock to the converter (counter bit 3) |
| adc_cs_n | output | 1 | Active-low chip-select to the converter |
| sample | output | 8 | Last captured conversion result, held for a frame |

## Verification
The bench contains a behavioural converter that watches `adc_sclk` and `adc_cs_n` and presents a chosen byte MSB first after a start slot. The values 0x00, 0xFF, 0x80, 0x01 and alternating patterns catch designs that swap bit order, shift in at the wrong end, or sample one edge early or late; such designs produce a shifted or mirrored byte. The held output is compared on every clock of every frame, which exposes a capture decoded at the wrong count (the output updates in the wrong cycle) or a holding register that follows the shift register (the output ripples mid-frame). A reset in the middle of a frame checks that every register clears and that the frame timing restarts from zero.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    // Single-cycle enables produced by the frame timer.
    typedef struct packed {
        logic shift;    // serial clock is about to fall
        logic capture;  // falling edge at the decoded capture count
    } adc_strobe_t;

    // True when the counter's low bits up to and including the serial-clock
    // bit are all ones, so the next increment drops the serial clock.
    function automatic logic sclk_falls_next(input logic [15:0] low_bits,
                                             input int          sclk_bit);
        logic all_ones;
        all_ones = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (i <= sclk_bit) all_ones &= low_bits[i];
        end
        return all_ones;
    endfunction

    // Chip-select is deasserted only in the last quarter of a frame.
    function automatic logic frame_cs_n(input logic [1:0] top_bits);
        return top_bits[1] & top_bits[0];
    endfunction

endpackage

// File: rtl/adc_frame_timer.sv
module adc_frame_timer
    import adc_frame_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SCLK_BIT = 3,
    parameter int CAP_CODE = 10
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_q,
    output logic             sclk,
    output logic             cs_n,
    output adc_strobe_t      strb
);
    localparam int TAG_W = CNT_W - SCLK_BIT - 1;

    logic [15:0] low_ext;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign sclk = cnt_q[SCLK_BIT];
    assign cs_n = frame_cs_n(cnt_q[CNT_W-1 -: 2]);

    always_comb begin
        low_ext = 16'(cnt_q[SCLK_BIT:0]);
        strb.shift   = sclk_falls_next(low_ext, SCLK_BIT);
        strb.capture = strb.shift &&
                       (cnt_q[CNT_W-1:SCLK_BIT+1] == TAG_W'(CAP_CODE));
    end

endmodule

// File: rtl/adc_serial_shifter.sv
module adc_serial_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {q[DATA_W-2:0], din};
    end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_frame_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SCLK_BIT = 3,
    parameter int DATA_W   = 8,
    parameter int CAP_CODE = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_sdata,
    output logic              adc_sclk,
    output logic              adc_cs_n,
    output logic [DATA_W-1:0] sample
);
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg;
    adc_strobe_t       strb;

    adc_frame_timer #(
        .CNT_W   (CNT_W),
        .SCLK_BIT(SCLK_BIT),
        .CAP_CODE(CAP_CODE)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .cnt_q(cnt_q),
        .sclk (adc_sclk),
        .cs_n (adc_cs_n),
        .strb (strb)
    );

    adc_serial_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk),
        .rst(rst),
        .en (strb.shift),
        .din(adc_sdata),
        .q  (shreg)
    );

    adc_result_hold #(.DATA_W(DATA_W)) u_hold (
        .clk (clk),
        .rst (rst),
        .load(strb.capture),
        .d   (shreg),
        .q   (sample)
    );

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_sclk,
    input logic              adc_cs_n,
    input logic [DATA_W-1:0] sample,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [DATA_W-1:0] shreg
);
    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1) |=> (cnt_q == '0));

    // R3
    frame_align_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> !adc_sclk);

    // R4
    shift_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (shreg != $past(shreg)) |-> ($past(adc_sclk) && !adc_sclk));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (sample != $past(sample)) |-> ($past(adc_sclk) && !adc_sclk && !adc_cs_n));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sample == '0 && shreg == '0 && !adc_sclk && !adc_cs_n));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .adc_sclk(adc_sclk),
    .adc_cs_n(adc_cs_n),
    .sample  (sample),
    .cnt_q   (cnt_q),
    .shreg   (shreg)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
    localparam int CLK_PERIOD = 250;
    localparam int CAP_CYCLE  = 176;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adc_sdata = 1'b0;
    logic       adc_sclk;
    logic       adc_cs_n;
    logic [7:0] sample;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // converter model state
    logic [7:0] cur_byte = 8'h00;
    int         edge_cnt = 0;
    logic       prev_cs  = 1'b1;
    logic       prev_sck = 1'b0;
    logic [7:0] prev_val = 8'h00;

    adc_frame_reader u_dut (
        .clk      (clk),
        .rst      (rst),
        .adc_sdata(adc_sdata),
        .adc_sclk (adc_sclk),
        .adc_cs_n (adc_cs_n),
        .sample   (sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // converter: start slot, then MSB first after the second falling edge
    task automatic model_update();
        if (rst)                           edge_cnt = 0;
        else if (prev_cs && !adc_cs_n)     edge_cnt = 0;
        else if (!adc_cs_n && prev_sck && !adc_sclk) edge_cnt++;
        prev_cs  = adc_cs_n;
        prev_sck = adc_sclk;
        if (!adc_cs_n && edge_cnt >= 2 && edge_cnt <= 9)
            adc_sdata = cur_byte[9 - edge_cnt];
        else
            adc_sdata = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_update();
    endtask

    function automatic logic [7:0] exp_sample(input int c, input logic [7:0] b,
                                              input logic [7:0] old);
        return (c >= CAP_CYCLE) ? b : old;
    endfunction

    // Runs cycles 0..ncyc-1 of a frame; sample point sits at counter value c.
    task automatic run_frame(input logic [7:0] b, input int ncyc);
        cur_byte = b;
        for (int c = 0; c < ncyc; c++) begin
            logic [7:0] cv;
            cv = 8'(c);
            check(adc_sclk == cv[3], "R2 sclk", int'(adc_sclk), int'(cv[3]));
            check(adc_cs_n == (cv[7] & cv[6]), "R3 cs_n", int'(adc_cs_n), int'(cv[7] & cv[6]));
            check(sample == exp_sample(c, b, prev_val), "R5/R6 sample timing",
                  int'(sample), int'(exp_sample(c, b, prev_val)));
            if (c == 255)
                check(sample == b, "R4/R8 captured byte", int'(sample), int'(b));
            tick();
        end
        if (ncyc == 256) begin
            prev_val = b;
            // R1: frame wraps, new frame begins with cs_n low and sclk low
            check(!adc_cs_n && !adc_sclk, "R1 wrap", int'({adc_cs_n, adc_sclk}), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] dir [6];
        void'($urandom(32'h5EED_0A0C));
        dir[0] = 8'h00; dir[1] = 8'hFF; dir[2] = 8'h80;
        dir[3] = 8'h01; dir[4] = 8'hA5; dir[5] = 8'h5A;

        rst = 1'b1;
        repeat (4) tick();
        // R7 reset state
        check(sample == 8'h00, "R7 reset sample", int'(sample), 0);
        check(!adc_sclk && !adc_cs_n, "R7 reset sclk/cs_n", int'({adc_sclk, adc_cs_n}), 0);
        rst = 1'b0;

        foreach (dir[i]) run_frame(dir[i], 256);
        for (int k = 0; k < 5; k++) run_frame(8'($urandom()), 256);

        // R7 reset in mid-frame after a capture has loaded a value
        run_frame(8'hC3, 256);
        run_frame(8'h3C, 200);
        rst = 1'b1;
        repeat (3) tick();
        check(sample == 8'h00, "R7 mid-frame reset sample", int'(sample), 0);
        check(!adc_sclk && !adc_cs_n, "R7 mid-frame reset sclk/cs_n",
              int'({adc_sclk, adc_cs_n}), 0);
        rst = 1'b0;
        prev_val = 8'h00;
        run_frame(8'h96, 256);
        run_frame(8'($urandom()), 256);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule